// File: doc/BRIEF.md
# Serial Register Access Controller

This block is a four-wire synchronous serial slave. It gives a host read and write access to a bank of sixteen 8-bit registers. Chip select is active low. The serial clock, serial data in and chip select are brought into the system clock domain through synchronizer stages, and every edge is detected there. A transaction always begins with a command byte. The command carries a burst flag in bit 7, a register address in bits 4:1 and a direction flag in bit 0. Bits 6:5 are reserved.

The command is followed by data bytes. A single-register command moves one byte. A burst command moves bytes through the whole bank in rising address order. The parallel side presents every register at once on a flat vector. Slot 0 is a read-only status value that is supplied from outside the block.

All serial bytes travel least significant bit first. The block samples serial data in on the rising serial clock edge and changes serial data out on the falling edge. Raising chip select ends any transfer at once.

Top module: `sra_ctrl`

## Requirements
- R1: After reset, registers 1 to 15 read 0 on the parallel vector, and the serial output enable is low.
- R2: A single write command (bit 7 = 0, bits 6:5 = 00, bits 4:1 = address, bit 0 = 0) followed by one complete byte stores that byte in the addressed register.
- R3: A single read command (bit 0 = 1) makes the block drive the addressed register on serial data out, least significant bit first. Each bit changes on a falling serial clock edge and is valid at the next rising edge.
- R4: Register 0 always returns the live status input, on the serial port and in slot 0 of the parallel vector. Writes to it change nothing, whether they come from a single or a burst write.
- R5: Command 0x80 (burst write) sends successive data bytes to registers 0, 1, 2 and so on up to 15, in that order.
- R6: Command 0x81 (burst read) returns registers 0 to 15 in ascending order, one byte each.
- R7: A burst command (bit 7 = 1) with a nonzero address field is ignored. No register changes, and serial data out stays 0 for the rest of that select period.
- R8: When chip select rises, the transfer ends. A partly received data byte is discarded, and the next select period starts with a new command.
- R9: The output enable is high while the synchronized chip select is low, and low while it is high.
- R10: A single-register command with nonzero reserved bits 6:5 is ignored.
- R11: Bytes that follow the end of a single transfer, or that follow the sixteenth byte of a burst, have no effect. During reads they return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo; low means the pad is high impedance |
| status_i | input | 8 | Read-only value shown as register 0 |
| cfg_o | output | 128 | All sixteen registers, register n in bits 8n+7:8n |

## Verification
The assertions assume that the host keeps chip select stable around every serial clock edge. They also assume that the serial clock stays in each level for several system clock cycles, so that each synchronized edge is seen exactly once and no rising and falling edge share a cycle. The stimulus holds each serial clock level for six system clocks. It changes serial data in only while the serial clock is low. It waits a half period after lowering chip select and before raising it, so every command, byte and partial byte reaches the state machine as a clean sequence of edges.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE,
        ST_DROP
    } sra_state_e;

    localparam int CMD_W = 8;

endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
    parameter int         N       = 3,
    parameter int         STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
                else        chain_q <= chain_d;
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sra_regbank.sv
module sra_regbank #(
    parameter int           NREG    = 16,
    parameter int           DW      = 8,
    parameter logic [DW-1:0] RST_VAL = '0,
    localparam int          AW      = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic [DW-1:0]      status_i,
    output logic [NREG*DW-1:0] cfg_o
);

    logic [NREG-1:1][DW-1:0] regs_d;
    logic [NREG-1:1][DW-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 1; i < NREG; i++) begin
            if (wr_en && (wr_addr == AW'(i))) regs_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= {(NREG-1){RST_VAL}};
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = status_i;
        for (int i = 1; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs_q[i];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_slot
            if (g == 0) begin : g_status
                assign cfg_o[DW-1:0] = status_i;
            end else begin : g_reg
                assign cfg_o[g*DW +: DW] = regs_q[g];
            end
        end
    endgenerate

    // R2: contents move only on a write strobe
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R4: a write aimed at the status slot leaves the bank untouched
    assert_status_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> $stable(regs_q));

endmodule

// File: rtl/sra_shifter.sv
module sra_shifter
    import sra_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG),
    localparam int SW  = (CMD_W > DW) ? CMD_W : DW,
    localparam int CW  = $clog2(SW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);

    localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);
    localparam logic [AW-1:0] ADDR_TOP  = AW'(NREG - 1);

    typedef struct packed {
        sra_state_e    st;
        logic [CW-1:0] cnt;
        logic [SW-1:0] sh_in;
        logic [DW-1:0] sh_out;
        logic [AW-1:0] addr;
        logic          burst;
        logic          sclk_prev;
        logic          sdo;
        logic          oe;
    } shf_t;

    shf_t q, d;

    logic             rise, fall;
    logic [SW-1:0]    shifted;
    logic [CMD_W-1:0] cmd;
    logic             cmd_rw, cmd_burst, cmd_bad;
    logic [AW-1:0]    cmd_addr;

    assign rise    = sclk_s & ~q.sclk_prev;
    assign fall    = ~sclk_s & q.sclk_prev;
    assign shifted = {sdi_s, q.sh_in[SW-1:1]};
    assign cmd     = shifted[SW-1 -: CMD_W];

    always_comb begin
        cmd_rw    = cmd[0];
        cmd_addr  = cmd[AW:1];
        cmd_burst = cmd[CMD_W-1];
        if (cmd_burst) cmd_bad = (cmd_addr != '0);
        else           cmd_bad = (cmd[CMD_W-2:AW+1] != '0);
    end

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        d.oe        = ~cs_n_s;
        wr_en       = 1'b0;
        wr_addr     = q.addr;
        wr_data     = shifted[SW-1 -: DW];
        rd_addr     = q.addr;

        if (cs_n_s) begin
            d.st    = ST_IDLE;
            d.cnt   = '0;
            d.sdo   = 1'b0;
            d.burst = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        d.sh_in = shifted;
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CMD_LAST) begin
                            d.cnt = '0;
                            if (cmd_bad) begin
                                d.st = ST_DROP;
                            end else begin
                                d.burst = cmd_burst;
                                d.addr  = cmd_burst ? '0 : cmd_addr;
                                rd_addr = d.addr;
                                if (cmd_rw) begin
                                    d.st     = ST_RD;
                                    d.sh_out = rd_data;
                                end else begin
                                    d.st = ST_WR;
                                end
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (rise) begin
                        d.sh_in = shifted;
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == DATA_LAST) begin
                            d.cnt = '0;
                            wr_en = 1'b1;
                            if (q.burst && q.addr != ADDR_TOP) d.addr = q.addr + 1'b1;
                            else                               d.st   = ST_DONE;
                        end
                    end
                end
                ST_RD: begin
                    if (fall) begin
                        d.sdo    = q.sh_out[0];
                        d.sh_out = q.sh_out >> 1;
                    end
                    if (rise) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == DATA_LAST) begin
                            d.cnt = '0;
                            if (q.burst && q.addr != ADDR_TOP) begin
                                d.addr   = q.addr + 1'b1;
                                rd_addr  = d.addr;
                                d.sh_out = rd_data;
                            end else begin
                                d.st = ST_DONE;
                            end
                        end
                    end
                end
                default: begin
                    d.sdo = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sdo    = q.sdo;
    assign sdo_oe = q.oe;

    // R9: a deselected port releases the data line one cycle later
    assert_oe_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdo_oe);

    // R8: raising select always returns the engine to idle
    assert_select_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.st == ST_IDLE));

    // R7: a rejected command never produces a write
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DROP) |-> !wr_en);

    // R3: read transfers never write
    assert_read_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD) |-> !wr_en);

    // R5: each burst write step moves to the next address or finishes
    assert_burst_ascends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.burst && !cs_n_s)
        |=> ((q.addr == $past(q.addr) + 1'b1) || (q.st == ST_DONE)));

endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl #(
    parameter int           NREG        = 16,
    parameter int           DW          = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [DW-1:0] RST_VAL     = '0,
    localparam int          AW          = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    input  logic [DW-1:0]      status_i,
    output logic [NREG*DW-1:0] cfg_o
);

    logic [2:0]    line_s;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;

    sra_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdi}),
        .sync_o  (line_s)
    );

    sra_shifter #(
        .NREG (NREG),
        .DW   (DW)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (line_s[2]),
        .sclk_s  (line_s[1]),
        .sdi_s   (line_s[0]),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    sra_regbank #(
        .NREG    (NREG),
        .DW      (DW),
        .RST_VAL (RST_VAL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .status_i (status_i),
        .cfg_o    (cfg_o)
    );

endmodule

// File: tb/sra_ctrl_tb.sv
module sra_ctrl_tb_top;

    localparam int H = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         sdo, sdo_oe;
    logic [7:0]   status_i = 8'h5C;
    logic [127:0] cfg_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16];

    always #10 clk = ~clk;

    sra_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe), .status_i (status_i), .cfg_o (cfg_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic desel();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[i];
            wait_clk(H);
            rx[i] = sdo;
            sclk = 1'b1;
            wait_clk(H);
            sclk = 1'b0;
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 16; i++) begin
            check(req, int'(cfg_o[i*8 +: 8]), (i == 0) ? int'(status_i) : int'(model[i]));
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] rx;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset contents and released output
        check_bank("R1");
        check("R1 oe", int'(sdo_oe), 0);

        // R2: single writes to every writable register
        for (int a = 1; a < 16; a++) begin
            sel();
            check("R9 oe on", int'(sdo_oe), 1);
            xfer(8'(a << 1), 8, rx);
            xfer(8'(a * 29 + 7), 8, rx);
            desel();
            check("R9 oe off", int'(sdo_oe), 0);
            model[a] = 8'(a * 29 + 7);
        end
        check_bank("R2");

        // R3 and R4: single reads of all addresses
        for (int a = 0; a < 16; a++) begin
            sel();
            xfer(8'((a << 1) | 1), 8, rx);
            xfer(8'h00, 8, rx);
            desel();
            check((a == 0) ? "R4 read" : "R3", int'(rx), (a == 0) ? int'(status_i) : int'(model[a]));
        end

        // R4: a single write to the status slot is ignored
        sel();
        xfer(8'h00, 8, rx);
        xfer(8'hFF, 8, rx);
        desel();
        check_bank("R4 single");

        // R5, R4, R11: burst write then an extra byte
        status_i = 8'hA7;
        sel();
        xfer(8'h80, 8, rx);
        for (int i = 0; i < 16; i++) begin
            xfer(8'h3C ^ 8'(i * 17), 8, rx);
            if (i != 0) model[i] = 8'h3C ^ 8'(i * 17);
        end
        xfer(8'h55, 8, rx);
        desel();
        check_bank("R5 R11");

        // R6, R11: burst read then an extra byte
        sel();
        xfer(8'h81, 8, rx);
        for (int i = 0; i < 16; i++) begin
            xfer(8'h00, 8, rx);
            check("R6", int'(rx), (i == 0) ? int'(status_i) : int'(model[i]));
        end
        xfer(8'h00, 8, rx);
        check("R11 burst tail", int'(rx), 0);
        desel();

        // R7: burst commands with nonzero addresses
        for (int a = 1; a < 16; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                sel();
                xfer(8'(8'h80 | (a << 1) | rw), 8, rx);
                xfer(8'h00, 8, rx);
                xfer(8'h00, 8, rx);
                desel();
                if (rw == 1) check("R7 sdo", int'(rx), 0);
            end
        end
        check_bank("R7");

        // R10: reserved bits set in a single write
        sel();
        xfer(8'h20 | 8'(3 << 1), 8, rx);
        xfer(8'hEE, 8, rx);
        desel();
        sel();
        xfer(8'h40 | 8'(4 << 1), 8, rx);
        xfer(8'hEE, 8, rx);
        desel();
        check_bank("R10");

        // R8: partial single byte
        sel();
        xfer(8'(7 << 1), 8, rx);
        xfer(8'hFF, 5, rx);
        desel();
        check("R8 single", int'(cfg_o[7*8 +: 8]), int'(model[7]));

        // R8: burst cut inside the fifth byte
        sel();
        xfer(8'h80, 8, rx);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h90 + 8'(i), 8, rx);
            if (i != 0) model[i] = 8'h90 + 8'(i);
        end
        xfer(8'hFF, 3, rx);
        desel();
        check_bank("R8 burst");

        // R8: a fresh transaction after a cut one
        sel();
        xfer(8'(2 << 1) | 8'h01, 8, rx);
        xfer(8'h00, 8, rx);
        desel();
        check("R8 fresh", int'(rx), int'(model[2]));

        // R11: second byte of a single write and of a single read
        sel();
        xfer(8'(9 << 1), 8, rx);
        xfer(8'h3C, 8, rx);
        xfer(8'h99, 8, rx);
        desel();
        model[9] = 8'h3C;
        check_bank("R11 single");
        sel();
        xfer(8'(9 << 1) | 8'h01, 8, rx);
        xfer(8'h00, 8, rx);
        check("R11 read first", int'(rx), 8'h3C);
        xfer(8'h00, 8, rx);
        check("R11 read tail", int'(rx), 0);
        desel();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule